// File: doc/BRIEF.md
# DDC Slave Bus Event Interrupt Unit

This block watches one display data channel, a two-wire bus with a clock line (SCL) and a data line (SDA). It samples both lines with the system clock. After reset it sits in the transmit-only legacy mode and does not drive the bus. When the host first pulls SCL low or issues a START, the block moves to two-wire slave mode and stays there until reset. In slave mode it decodes START and STOP, shifts in the address byte and compares it with the programmed own address. It acknowledges a match and then either receives bytes into a receive holding register or sends bytes from a transmit holding register. In send mode it samples the host's acknowledge on the ninth clock.

Six slave events set sticky flags: mode switch (bit 0), address match (bit 1), transmit holding register taken (bit 2), byte received (bit 3), host not-acknowledge (bit 4) and STOP (bit 5). Software clears a flag by writing 1 to its clear strobe. Each flag has its own enable, and the enabled flags are ORed into a single interrupt request.

The control sequencer has eight states. `ST_IDLE` waits for START. `ST_ADDR` shifts in the address byte. It goes to `ST_ADDR_ACK` on a match and back to `ST_IDLE` on a mismatch. `ST_ADDR_ACK` drives the ACK for one SCL low-high-low period. It then goes to `ST_TX` when the R/W bit is 1, loading the shifter, or to `ST_RX` when the R/W bit is 0. `ST_RX` shifts in a data byte, and `ST_RX_ACK` acknowledges it and returns to `ST_RX`. `ST_TX` drives eight bits. `ST_TX_ACK` releases SDA and samples the host's answer on the ninth rising SCL edge. An ACK leads to `ST_TX_NEXT`. A NACK leads to `ST_IDLE`. `ST_TX_NEXT` reloads the shifter at the next falling SCL edge and returns to `ST_TX`. In slave mode, any STOP sends every state to `ST_IDLE`, and any START sends every state to `ST_ADDR`.

Top module: `ddc_evt_unit`

## Requirements
- R1: After reset the unit is in legacy mode (`ddc2_mode`=0), all flags are 0, `irq_o` is 0 and `sda_oe` is 0.
- R2: In legacy mode SDA is never driven. A falling SCL edge or a START (SDA falling while SCL is high) sets flag bit 0 and sets `ddc2_mode`, which then stays 1 until reset.
- R3: When the first seven bits after a START (MSB first) equal `own_addr`, flag bit 1 is set and SDA is pulled low (`sda_oe`=1) during the ninth clock.
- R4: A non-matching address is ignored. There is no ACK, and neither flag bit 1 nor flag bit 3 is set. `rx_data` is unchanged until the next START.
- R5: With R/W (eighth address bit) = 0, each following byte is acknowledged, stored into `rx_data` and sets flag bit 3.
- R6: With R/W = 1, the byte captured by `tx_load` from `tx_data` moves into the shifter at the end of the address ACK. This sets flag bit 2, and the byte is sent MSB first (`sda_oe`=1 sends a 0).
- R7: In send mode, a host ACK (SDA low on the ninth rising SCL edge) reloads the shifter with the current holding byte and sets flag bit 2 again. A host NACK sets flag bit 4 and returns the unit to idle with SDA released.
- R8: In slave mode a STOP (SDA rising while SCL is high) sets flag bit 5 and returns the unit to idle.
- R9: Flags are sticky. A 1 on `irq_clr` bit i clears flag i, except in a cycle where flag i is also being set, when the flag stays 1.
- R10: `irq_o` is 1 exactly when some flag bit and the matching `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level from the bus |
| sda_i | input | 1 | SDA line level from the bus |
| own_addr | input | 7 | Programmed 7-bit slave address |
| tx_data | input | 8 | Byte for the transmit holding register |
| tx_load | input | 1 | Strobe that captures `tx_data` |
| irq_en | input | 6 | Per-event enable |
| irq_clr | input | 6 | Per-event write-1-to-clear strobe |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ddc2_mode | output | 1 | 1 once slave mode is entered |
| rx_data | output | 8 | Receive holding register |
| irq_flags | output | 6 | Sticky event flags |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The hardest situation to reach from the ports is a flag being set in the very cycle its clear strobe is high. This depends on the synchronizer depth and the edge-detect register. The bench counts those stages from the cycle SDA rises to form a STOP and places a one-cycle clear pulse exactly on the setting edge. It then repeats the test one cycle later to show that the clear does take effect. The legacy-to-slave switch is reached in both ways, by a bare SCL low pulse and by a START, each after a fresh reset. Multi-byte reads with an ACK between bytes and a NACK at the end need the bench to reload the holding register in the middle of each byte. The bench does this while random addresses, directions and payloads run against a bus model.

// File: rtl/ddc_evt_pkg.sv
package ddc_evt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int NUM_EV = 6;
    localparam int CNT_W  = $clog2(DATA_W);

    localparam int EV_GOLOW = 0;
    localparam int EV_ADDR  = 1;
    localparam int EV_TXE   = 2;
    localparam int EV_RX    = 3;
    localparam int EV_NACK  = 4;
    localparam int EV_STOP  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT
    } slv_state_e;
endpackage

// File: rtl/ddc_line_mon.sv
module ddc_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0][1:0] stg;
    logic                   scl_d, sda_d;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg   <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            stg[0] <= {scl_in, sda_in};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            scl_d <= stg[STAGES-1][1];
            sda_d <= stg[STAGES-1][0];
        end
    end

    assign scl_s     = stg[STAGES-1][1];
    assign sda_lvl   = stg[STAGES-1][0];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_lvl;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ddc_slave_fsm.sv
module ddc_slave_fsm
    import ddc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              sda_oe,
    output logic              ddc2_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic [NUM_EV-1:0] ev_set
);
    slv_state_e        st, st_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] sh;
    logic [DATA_W-1:0] tx_hold, tx_sh;
    logic              rw, ack_on, load_tx, byte_done, addr_hit, shifting;

    assign byte_done = scl_rise && (bit_cnt == CNT_W'(DATA_W-1));
    assign addr_hit  = (sh == own_addr);
    assign shifting  = (st == ST_ADDR) || (st == ST_RX) || (st == ST_TX);

    // next state and event pulses
    always_comb begin
        st_n    = st;
        ev_set  = '0;
        load_tx = 1'b0;
        if (!ddc2_mode) begin
            if (bus_start || scl_fall) ev_set[EV_GOLOW] = 1'b1;
            if (bus_start) st_n = ST_ADDR;
        end else if (bus_stop) begin
            ev_set[EV_STOP] = 1'b1;
            st_n = ST_IDLE;
        end else if (bus_start) begin
            st_n = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: if (byte_done) begin
                    st_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                    ev_set[EV_ADDR] = addr_hit;
                end
                ST_ADDR_ACK: if (scl_fall && ack_on) begin
                    if (rw) begin
                        st_n = ST_TX;
                        load_tx = 1'b1;
                        ev_set[EV_TXE] = 1'b1;
                    end else begin
                        st_n = ST_RX;
                    end
                end
                ST_RX: if (byte_done) begin
                    st_n = ST_RX_ACK;
                    ev_set[EV_RX] = 1'b1;
                end
                ST_RX_ACK: if (scl_fall && ack_on) st_n = ST_RX;
                ST_TX: if (byte_done) st_n = ST_TX_ACK;
                ST_TX_ACK: if (scl_rise) begin
                    if (sda_lvl) begin
                        ev_set[EV_NACK] = 1'b1;
                        st_n = ST_IDLE;
                    end else begin
                        st_n = ST_TX_NEXT;
                    end
                end
                ST_TX_NEXT: if (scl_fall) begin
                    load_tx = 1'b1;
                    ev_set[EV_TXE] = 1'b1;
                    st_n = ST_TX;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddc2_mode <= 1'b0;
            bit_cnt   <= '0;
            sh        <= '0;
            rw        <= 1'b0;
            ack_on    <= 1'b0;
            sda_oe    <= 1'b0;
            rx_data   <= '0;
            tx_hold   <= '0;
            tx_sh     <= '0;
        end else begin
            if (ev_set[EV_GOLOW]) ddc2_mode <= 1'b1;
            if (tx_load) tx_hold <= tx_data;

            if (bus_start || st_n != st)    bit_cnt <= '0;
            else if (scl_rise && shifting)  bit_cnt <= bit_cnt + 1'b1;

            if (scl_rise && (st == ST_ADDR || st == ST_RX)) sh <= {sh[DATA_W-3:0], sda_lvl};
            if (st == ST_ADDR && byte_done) rw <= sda_lvl;
            if (ev_set[EV_RX]) rx_data <= {sh, sda_lvl};

            if (st_n != st) ack_on <= 1'b0;
            else if (scl_fall && (st == ST_ADDR_ACK || st == ST_RX_ACK)) ack_on <= 1'b1;

            if (st_n == ST_IDLE || bus_start) begin
                sda_oe <= 1'b0;
            end else if (load_tx) begin
                sda_oe <= ~tx_hold[DATA_W-1];
                tx_sh  <= {tx_hold[DATA_W-2:0], 1'b0};
            end else if (scl_fall) begin
                unique case (st)
                    ST_ADDR_ACK, ST_RX_ACK: sda_oe <= ~ack_on;
                    ST_TX: begin
                        sda_oe <= ~tx_sh[DATA_W-1];
                        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ddc_irq_bank.sv
module ddc_irq_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_i) | set_i;
    end

    assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/ddc_evt_unit.sv
module ddc_evt_unit
    import ddc_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic [NUM_EV-1:0] irq_en,
    input  logic [NUM_EV-1:0] irq_clr,
    output logic              sda_oe,
    output logic              ddc2_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic [NUM_EV-1:0] irq_flags,
    output logic              irq_o
);
    logic              sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic [NUM_EV-1:0] ev_set;

    ddc_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    ddc_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .own_addr(own_addr), .tx_data(tx_data), .tx_load(tx_load),
        .sda_oe(sda_oe), .ddc2_mode(ddc2_mode), .rx_data(rx_data), .ev_set(ev_set)
    );

    ddc_irq_bank #(.N(NUM_EV)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(irq_clr),
        .en_i(irq_en), .flags_o(irq_flags), .irq_o(irq_o)
    );
endmodule

// File: rtl/ddc_evt_chk.sv
module ddc_evt_chk
    import ddc_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              ddc2_mode,
    input logic [NUM_EV-1:0] irq_en,
    input logic [NUM_EV-1:0] irq_clr,
    input logic [NUM_EV-1:0] irq_flags,
    input logic              irq_o
);
    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ddc2_mode |=> ddc2_mode);

    assert_no_drive_legacy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ddc2_mode |-> !sda_oe);

    assert_golow_with_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[EV_GOLOW]) |-> $rose(ddc2_mode));

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq_o);

    assert_nack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[EV_NACK]) |-> !sda_oe);
endmodule

bind ddc_evt_unit ddc_evt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ddc2_mode(ddc2_mode),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_flags(irq_flags), .irq_o(irq_o)
);

// File: tb/tb_ddc_evt_unit.sv
module tb_ddc_evt_unit;
    localparam int HP = 10;
    localparam logic [6:0] OWN = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1, host_sda = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [5:0] irq_en = '0, irq_clr = '0;
    logic       sda_oe, ddc2_mode, irq_o;
    logic [7:0] rx_data;
    logic [5:0] irq_flags;
    logic       sda_bus;
    int         n_chk = 0, n_err = 0;
    logic [7:0] pay [8];
    logic [7:0] last_rx = '0;

    assign sda_bus = host_sda & ~sda_oe;

    always #2 clk = ~clk;

    ddc_evt_unit dut (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
        .own_addr(OWN), .tx_data(tx_data), .tx_load(tx_load),
        .irq_en(irq_en), .irq_clr(irq_clr), .sda_oe(sda_oe),
        .ddc2_mode(ddc2_mode), .rx_data(rx_data), .irq_flags(irq_flags), .irq_o(irq_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_flags(input bit match, input bit rd, input int n);
        logic [5:0] f = 6'b100000;
        if (match) begin
            f[1] = 1'b1;
            if (rd) begin f[2] = 1'b1; f[4] = 1'b1; end
            else if (n > 0) f[3] = 1'b1;
        end
        return f;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; host_scl = 1'b1; host_sda = 1'b1; irq_clr = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
    endtask

    task automatic bus_start();
        host_sda = 1'b0; cyc(HP);
        host_scl = 1'b0; cyc(HP);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; cyc(HP);
        host_scl = 1'b1; cyc(HP);
        host_sda = 1'b1; cyc(HP);
    endtask

    task automatic put_bit(input logic b);
        host_sda = b; cyc(HP);
        host_scl = 1'b1; cyc(HP);
        host_scl = 1'b0; cyc(HP);
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; cyc(HP);
        host_scl = 1'b1; cyc(HP/2);
        b = sda_bus; cyc(HP/2);
        host_scl = 1'b0; cyc(HP);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1; cyc(1); tx_load = 1'b0;
    endtask

    task automatic clear_all();
        irq_clr = '1; cyc(1); irq_clr = '0; cyc(1);
    endtask

    task automatic write_txn(input logic [6:0] a, input int n);
        logic ack;
        bit   hit = (a == OWN);
        bus_start();
        put_byte({a, 1'b0}, ack);
        check(hit ? "R3 addr ack" : "R4 no ack on mismatch", ack, hit ? 0 : 1);
        for (int k = 0; k < n; k++) begin
            put_byte(pay[k], ack);
            check(hit ? "R5 data ack" : "R4 data ignored", ack, hit ? 0 : 1);
            if (hit) begin
                last_rx = pay[k];
                check("R5 rx_data", rx_data, pay[k]);
            end else begin
                check("R4 rx_data kept", rx_data, last_rx);
            end
        end
        bus_stop();
        check("R8 R3 R5 flags after write", irq_flags, exp_flags(hit, 1'b0, n));
    endtask

    task automatic read_txn(input int n);
        logic       ack;
        logic [7:0] got;
        load_tx(pay[0]);
        bus_start();
        put_byte({OWN, 1'b1}, ack);
        check("R3 addr ack (read)", ack, 0);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                get_bit(got[i]);
                if (i == 7 && k + 1 < n) load_tx(pay[k+1]);
            end
            check("R6 R7 byte sent", got, pay[k]);
            put_bit(k == n - 1);
            check("R7 released after host bit", sda_oe, (k == n - 1) ? 0 : 1 - pay[k+1 < n ? k+1 : k][7]);
        end
        bus_stop();
        check("R6 R7 R8 flags after read", irq_flags, exp_flags(1'b1, 1'b1, n));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int s;
        s = $urandom(32'd4242);
        do_reset();
        // R1: reset state
        check("R1 mode", ddc2_mode, 0);
        check("R1 flags", irq_flags, 0);
        check("R1 irq", irq_o, 0);
        check("R1 oe", sda_oe, 0);

        // R2: bare SCL low pulse switches mode
        host_scl = 1'b0; cyc(HP);
        check("R2 switch on SCL low", ddc2_mode, 1);
        check("R2 flag0 on SCL low", irq_flags, 6'b000001);
        host_scl = 1'b1; cyc(HP);
        clear_all();
        check("R9 cleared", irq_flags, 0);
        check("R2 stays slave mode", ddc2_mode, 1);

        // R2: START path after a fresh reset, then a write
        do_reset();
        check("R1 mode after reset", ddc2_mode, 0);
        pay[0] = 8'hA5; pay[1] = 8'h3C;
        bus_start();
        check("R2 switch on START", ddc2_mode, 1);
        check("R2 flag0 on START", irq_flags[0], 1);
        begin
            logic ack;
            put_byte({OWN, 1'b0}, ack);
            check("R3 addr ack", ack, 0);
            check("R3 flag1", irq_flags[1], 1);
            put_byte(pay[0], ack);
            check("R5 ack", ack, 0);
            check("R5 rx_data", rx_data, 8'hA5);
            last_rx = 8'hA5;
        end
        bus_stop();
        check("R8 flags", irq_flags, 6'b101011);
        clear_all();

        // R7: single-byte read with NACK
        pay[0] = 8'h81;
        read_txn(1);
        clear_all();

        // R9: set and clear in the same cycle keeps the flag
        host_scl = 1'b0; cyc(2);
        host_sda = 1'b0; cyc(HP);
        host_scl = 1'b1; cyc(HP);
        host_sda = 1'b1; cyc(2);
        irq_clr = 6'b100000; cyc(1);
        irq_clr = '0; cyc(2);
        check("R9 set wins over clear", irq_flags, 6'b100000);
        // one cycle later the clear takes effect
        host_scl = 1'b0; cyc(2);
        host_sda = 1'b0; cyc(HP);
        host_scl = 1'b1; cyc(HP);
        host_sda = 1'b1; cyc(3);
        irq_clr = 6'b100000; cyc(1);
        irq_clr = '0; cyc(2);
        check("R9 clear after set", irq_flags, 6'b000000);

        // random transactions
        for (int t = 0; t < 30; t++) begin
            int         kind = $urandom_range(0, 2);
            int         n = $urandom_range(1, 4);
            logic [6:0] a;
            logic [5:0] en;
            for (int k = 0; k < 8; k++) pay[k] = 8'($urandom);
            if (kind == 2) begin
                a = OWN ^ 7'($urandom_range(1, 127));
                write_txn(a, n);
            end else if (kind == 1) begin
                read_txn(n);
            end else begin
                write_txn(OWN, n);
            end
            en = 6'($urandom);
            irq_en = en; cyc(1);
            check("R10 irq", irq_o, |(irq_flags & en));
            irq_en = '0; cyc(1);
            check("R10 masked", irq_o, 0);
            clear_all();
            check("R9 cleared", irq_flags, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule